// File: doc/BRIEF.md
# Lockstep Engine Array Cycle Controller

This block sequences a group of processing engines that must all run the same processing cycle together. The host issues commands through a simple request/acknowledge port. A single-step command runs exactly one cycle. A run command repeats cycles until the host halts them. For each cycle the controller raises one start pulse on every engine at once. It then gathers the engines' completion pulses, which may arrive in different clocks, and only when every engine has reported does it close the cycle and count it.

The same host port reaches the shared memory and the private memory of any one engine. Shared-memory accesses are allowed at any time. An access to an engine's private memory is only carried out while the array is idle. Such a request made during activity gets an immediate error response, so the host is never stalled. Memory accesses use a request/acknowledge handshake toward the memories and may take several clocks. The host can also read a busy flag and a 32-bit count of completed cycles.

Top module: `lockstep_array_ctrl`

## Requirements
- R1: After reset the array is idle: `array_busy` is 0, `eng_start` is all zero, `host_ack` is 0 and the completed-cycle count reads 0.
- R2: Op code 0 (single step) accepted while idle produces exactly one start pulse, after which the array returns to idle and the completed-cycle count rises by exactly one. Op code 2 (halt) issued while idle is acknowledged without error and has no effect.
- R3: A cycle completes only after a done pulse has been seen from every engine, and the pulses may arrive in different clocks. With engine latencies D (clocks from start to done), `array_busy` stays high for max(D)+1 clocks, counted from the clock after the step command was sampled.
- R4: Op code 1 (run) starts repeated cycles. Each new start pulse follows the previous cycle's completion directly, so start pulses are spaced D+1 clocks apart when all engines have latency D.
- R5: Op code 2 (halt) during activity never aborts the current cycle. That cycle completes and is counted, and no further start pulse follows. A halt sampled in the same clock as the final done pulse is honoured at that boundary, so `array_busy` is already 0 when its acknowledge appears.
- R6: Op codes 5 (private read) and 6 (private write) issued while idle reach exactly the engine selected by `host_eng` at word `host_addr[LM_AW-1:0]`. A read returns that word on `host_rdata`, and `host_err` is 0.
- R7: A private-memory request made while the array is active is acknowledged with `host_err`=1, raises no `lm_req` bit, and leaves the engine's memory unchanged.
- R8: Op codes 3 (shared read) and 4 (shared write) are performed whether the array is idle or running, with `host_err`=0.
- R9: Op code 7 (status) returns the busy flag in bit 0 when `host_addr[0]`=0, and the completed-cycle count when `host_addr[0]`=1.
- R10: A step or run command issued while the array is active is refused with `host_err`=1 and starts no extra cycle.
- R11: Every start pulse is one clock wide and is asserted on all engines in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | One-clock host request; one outstanding at a time |
| host_op | input | 3 | Operation code (see requirements) |
| host_eng | input | ENG_W | Engine selected for a private-memory access |
| host_addr | input | SM_AW | Word address, or status selector in bit 0 |
| host_wdata | input | DATA_W | Write data |
| host_ack | output | 1 | One-clock response pulse |
| host_err | output | 1 | Request refused, valid with host_ack |
| host_rdata | output | DATA_W | Read data, valid with host_ack |
| array_busy | output | 1 | A cycle is being launched or awaited |
| eng_start | output | NUM_ENG | Broadcast start pulse, one bit per engine |
| eng_done | input | NUM_ENG | Per-engine completion pulse |
| sm_req | output | 1 | Shared-memory request, held until acknowledged |
| sm_we | output | 1 | Shared-memory write enable |
| sm_addr | output | SM_AW | Shared-memory word address |
| sm_wdata | output | DATA_W | Shared-memory write data |
| sm_rdata | input | DATA_W | Shared-memory read data, valid with sm_ack |
| sm_ack | input | 1 | Shared-memory acknowledge |
| lm_req | output | NUM_ENG | One-hot private-memory request, held until acknowledged |
| lm_we | output | 1 | Private-memory write enable |
| lm_addr | output | LM_AW | Private-memory word address |
| lm_wdata | output | DATA_W | Private-memory write data |
| lm_rdata | input | NUM_ENG*DATA_W | Private-memory read data, engine i at bits i*DATA_W upward |
| lm_ack | input | NUM_ENG | Per-engine private-memory acknowledge |

## Verification
The case that matters is a halt command that lands in the same clock as the final engine done pulse. At that point the run loop would normally relaunch. The bench gives every engine the same latency so that all done pulses coincide. It then watches the done lines between clock edges and presents the halt exactly while they are high. The result is judged at the ports: `array_busy` must already be low when the halt is acknowledged, no further start pulse may appear, and the completed-cycle count read back must equal the number of start pulses seen.

// File: rtl/lockstep_ctrl_pkg.sv
package lockstep_ctrl_pkg;

    typedef enum logic [2:0] {
        OP_STEP   = 3'd0,
        OP_RUN    = 3'd1,
        OP_HALT   = 3'd2,
        OP_SM_RD  = 3'd3,
        OP_SM_WR  = 3'd4,
        OP_LM_RD  = 3'd5,
        OP_LM_WR  = 3'd6,
        OP_STATUS = 3'd7
    } host_op_e;

    typedef enum logic [1:0] {
        RUN_IDLE,
        RUN_LAUNCH,
        RUN_WAIT
    } run_state_e;

    typedef enum logic [1:0] {
        HP_IDLE,
        HP_SM,
        HP_LM
    } port_state_e;

endpackage

// File: rtl/done_collector.sv
module done_collector #(
    parameter int NUM_ENG = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               capture,
    input  logic [NUM_ENG-1:0] done_in,
    output logic               all_done
);

    logic [NUM_ENG-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (clear) begin
            mask_d = '0;
        end else if (capture) begin
            mask_d = mask_q | done_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

    // Completion is seen in the clock the last outstanding engine reports.
    assign all_done = capture && (&(mask_q | done_in));

endmodule

// File: rtl/run_sequencer.sv
module run_sequencer
    import lockstep_ctrl_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_step,
    input  logic             cmd_run,
    input  logic             cmd_halt,
    input  logic             all_done,
    output logic             launch,
    output logic             waiting,
    output logic             busy,
    output logic [CNT_W-1:0] cycle_count
);

    typedef struct packed {
        run_state_e       state;
        logic             cont;
        logic             halt_pend;
        logic [CNT_W-1:0] count;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.state)
            RUN_IDLE: begin
                if (cmd_step) begin
                    seq_d.state     = RUN_LAUNCH;
                    seq_d.cont      = 1'b0;
                    seq_d.halt_pend = 1'b0;
                end else if (cmd_run) begin
                    seq_d.state     = RUN_LAUNCH;
                    seq_d.cont      = 1'b1;
                    seq_d.halt_pend = 1'b0;
                end
            end
            RUN_LAUNCH: begin
                seq_d.state = RUN_WAIT;
                if (cmd_halt) seq_d.halt_pend = 1'b1;
            end
            RUN_WAIT: begin
                if (cmd_halt) seq_d.halt_pend = 1'b1;
                if (all_done) begin
                    seq_d.count = seq_q.count + CNT_W'(1);
                    if (seq_q.cont && !seq_q.halt_pend && !cmd_halt) begin
                        seq_d.state = RUN_LAUNCH;
                    end else begin
                        seq_d.state     = RUN_IDLE;
                        seq_d.cont      = 1'b0;
                        seq_d.halt_pend = 1'b0;
                    end
                end
            end
            default: seq_d.state = RUN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.state     <= RUN_IDLE;
            seq_q.cont      <= 1'b0;
            seq_q.halt_pend <= 1'b0;
            seq_q.count     <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign launch      = (seq_q.state == RUN_LAUNCH);
    assign waiting     = (seq_q.state == RUN_WAIT);
    assign busy        = (seq_q.state != RUN_IDLE);
    assign cycle_count = seq_q.count;

endmodule

// File: rtl/host_access.sv
module host_access
    import lockstep_ctrl_pkg::*;
#(
    parameter int NUM_ENG = 4,
    parameter int DATA_W  = 32,
    parameter int SM_AW   = 16,
    parameter int LM_AW   = 12,
    parameter int CNT_W   = 32,
    parameter int ENG_W   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_req,
    input  logic [2:0]                host_op,
    input  logic [ENG_W-1:0]          host_eng,
    input  logic [SM_AW-1:0]          host_addr,
    input  logic [DATA_W-1:0]         host_wdata,
    output logic                      host_ack,
    output logic                      host_err,
    output logic [DATA_W-1:0]         host_rdata,
    input  logic                      busy,
    input  logic [CNT_W-1:0]          cycle_count,
    output logic                      cmd_step,
    output logic                      cmd_run,
    output logic                      cmd_halt,
    output logic                      sm_req,
    output logic                      sm_we,
    output logic [SM_AW-1:0]          sm_addr,
    output logic [DATA_W-1:0]         sm_wdata,
    input  logic [DATA_W-1:0]         sm_rdata,
    input  logic                      sm_ack,
    output logic [NUM_ENG-1:0]        lm_req,
    output logic                      lm_we,
    output logic [LM_AW-1:0]          lm_addr,
    output logic [DATA_W-1:0]         lm_wdata,
    input  logic [NUM_ENG*DATA_W-1:0] lm_rdata,
    input  logic [NUM_ENG-1:0]        lm_ack
);

    typedef struct packed {
        port_state_e       state;
        host_op_e          op;
        logic [ENG_W-1:0]  eng;
        logic [SM_AW-1:0]  addr;
        logic [DATA_W-1:0] wdata;
        logic              ack;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } port_t;

    port_t             pt_d, pt_q;
    logic              eng_ok;
    logic              sel_ack;
    logic [DATA_W-1:0] sel_rdata;
    host_op_e          req_op;

    assign req_op = host_op_e'(host_op);

    always_comb begin
        eng_ok    = 1'b0;
        sel_ack   = 1'b0;
        sel_rdata = '0;
        for (int i = 0; i < NUM_ENG; i++) begin
            if (host_eng == ENG_W'(i)) eng_ok = 1'b1;
            if (pt_q.eng == ENG_W'(i)) begin
                sel_ack   = lm_ack[i];
                sel_rdata = lm_rdata[i*DATA_W +: DATA_W];
            end
        end
    end

    always_comb begin
        pt_d     = pt_q;
        pt_d.ack = 1'b0;
        pt_d.err = 1'b0;
        cmd_step = 1'b0;
        cmd_run  = 1'b0;
        cmd_halt = 1'b0;
        case (pt_q.state)
            HP_IDLE: begin
                if (host_req) begin
                    pt_d.op    = req_op;
                    pt_d.eng   = host_eng;
                    pt_d.addr  = host_addr;
                    pt_d.wdata = host_wdata;
                    case (req_op)
                        OP_STEP: begin
                            pt_d.ack = 1'b1;
                            if (busy) pt_d.err = 1'b1;
                            else      cmd_step = 1'b1;
                        end
                        OP_RUN: begin
                            pt_d.ack = 1'b1;
                            if (busy) pt_d.err = 1'b1;
                            else      cmd_run  = 1'b1;
                        end
                        OP_HALT: begin
                            pt_d.ack = 1'b1;
                            cmd_halt = 1'b1;
                        end
                        OP_SM_RD, OP_SM_WR: begin
                            pt_d.state = HP_SM;
                        end
                        OP_LM_RD, OP_LM_WR: begin
                            if (busy || !eng_ok) begin
                                pt_d.ack = 1'b1;
                                pt_d.err = 1'b1;
                            end else begin
                                pt_d.state = HP_LM;
                            end
                        end
                        OP_STATUS: begin
                            pt_d.ack   = 1'b1;
                            pt_d.rdata = host_addr[0] ? DATA_W'(cycle_count)
                                                      : DATA_W'(busy);
                        end
                        default: pt_d.state = HP_IDLE;
                    endcase
                end
            end
            HP_SM: begin
                if (sm_ack) begin
                    pt_d.state = HP_IDLE;
                    pt_d.ack   = 1'b1;
                    pt_d.rdata = (pt_q.op == OP_SM_RD) ? sm_rdata : '0;
                end
            end
            HP_LM: begin
                if (sel_ack) begin
                    pt_d.state = HP_IDLE;
                    pt_d.ack   = 1'b1;
                    pt_d.rdata = (pt_q.op == OP_LM_RD) ? sel_rdata : '0;
                end
            end
            default: pt_d.state = HP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pt_q.state <= HP_IDLE;
            pt_q.op    <= OP_STEP;
            pt_q.eng   <= '0;
            pt_q.addr  <= '0;
            pt_q.wdata <= '0;
            pt_q.ack   <= 1'b0;
            pt_q.err   <= 1'b0;
            pt_q.rdata <= '0;
        end else begin
            pt_q <= pt_d;
        end
    end

    always_comb begin
        lm_req = '0;
        if (pt_q.state == HP_LM) begin
            for (int i = 0; i < NUM_ENG; i++) begin
                if (pt_q.eng == ENG_W'(i)) lm_req[i] = 1'b1;
            end
        end
    end

    assign host_ack   = pt_q.ack;
    assign host_err   = pt_q.err;
    assign host_rdata = pt_q.rdata;
    assign sm_req     = (pt_q.state == HP_SM);
    assign sm_we      = (pt_q.op == OP_SM_WR);
    assign sm_addr    = pt_q.addr;
    assign sm_wdata   = pt_q.wdata;
    assign lm_we      = (pt_q.op == OP_LM_WR);
    assign lm_addr    = pt_q.addr[LM_AW-1:0];
    assign lm_wdata   = pt_q.wdata;

endmodule

// File: rtl/lockstep_array_ctrl.sv
module lockstep_array_ctrl #(
    parameter int NUM_ENG = 4,
    parameter int DATA_W  = 32,
    parameter int SM_AW   = 16,
    parameter int LM_AW   = 12,
    parameter int CNT_W   = 32,
    localparam int ENG_W  = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_req,
    input  logic [2:0]                host_op,
    input  logic [ENG_W-1:0]          host_eng,
    input  logic [SM_AW-1:0]          host_addr,
    input  logic [DATA_W-1:0]         host_wdata,
    output logic                      host_ack,
    output logic                      host_err,
    output logic [DATA_W-1:0]         host_rdata,
    output logic                      array_busy,
    output logic [NUM_ENG-1:0]        eng_start,
    input  logic [NUM_ENG-1:0]        eng_done,
    output logic                      sm_req,
    output logic                      sm_we,
    output logic [SM_AW-1:0]          sm_addr,
    output logic [DATA_W-1:0]         sm_wdata,
    input  logic [DATA_W-1:0]         sm_rdata,
    input  logic                      sm_ack,
    output logic [NUM_ENG-1:0]        lm_req,
    output logic                      lm_we,
    output logic [LM_AW-1:0]          lm_addr,
    output logic [DATA_W-1:0]         lm_wdata,
    input  logic [NUM_ENG*DATA_W-1:0] lm_rdata,
    input  logic [NUM_ENG-1:0]        lm_ack
);

    logic             cmd_step, cmd_run, cmd_halt;
    logic             launch, waiting, all_done;
    logic [CNT_W-1:0] cycle_count;

    done_collector #(
        .NUM_ENG (NUM_ENG)
    ) u_join (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (launch),
        .capture  (waiting),
        .done_in  (eng_done),
        .all_done (all_done)
    );

    run_sequencer #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_step    (cmd_step),
        .cmd_run     (cmd_run),
        .cmd_halt    (cmd_halt),
        .all_done    (all_done),
        .launch      (launch),
        .waiting     (waiting),
        .busy        (array_busy),
        .cycle_count (cycle_count)
    );

    host_access #(
        .NUM_ENG (NUM_ENG),
        .DATA_W  (DATA_W),
        .SM_AW   (SM_AW),
        .LM_AW   (LM_AW),
        .CNT_W   (CNT_W),
        .ENG_W   (ENG_W)
    ) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_req    (host_req),
        .host_op     (host_op),
        .host_eng    (host_eng),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_ack    (host_ack),
        .host_err    (host_err),
        .host_rdata  (host_rdata),
        .busy        (array_busy),
        .cycle_count (cycle_count),
        .cmd_step    (cmd_step),
        .cmd_run     (cmd_run),
        .cmd_halt    (cmd_halt),
        .sm_req      (sm_req),
        .sm_we       (sm_we),
        .sm_addr     (sm_addr),
        .sm_wdata    (sm_wdata),
        .sm_rdata    (sm_rdata),
        .sm_ack      (sm_ack),
        .lm_req      (lm_req),
        .lm_we       (lm_we),
        .lm_addr     (lm_addr),
        .lm_wdata    (lm_wdata),
        .lm_rdata    (lm_rdata),
        .lm_ack      (lm_ack)
    );

    // Broadcast: one launch state drives every engine's start bit.
    genvar g;
    generate
        for (g = 0; g < NUM_ENG; g++) begin : g_start
            assign eng_start[g] = launch;
        end
    endgenerate

endmodule

// File: rtl/array_ctrl_checker.sv
module array_ctrl_checker #(
    parameter int NUM_ENG = 4,
    parameter int CNT_W   = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_ENG-1:0] eng_start,
    input logic [NUM_ENG-1:0] eng_done,
    input logic [NUM_ENG-1:0] lm_req,
    input logic               array_busy,
    input logic               host_ack,
    input logic               host_err,
    input logic [CNT_W-1:0]   cycle_count
);

    assert_start_lockstep_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start == '0) || (eng_start == {NUM_ENG{1'b1}}));

    assert_start_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|eng_start) |=> !(|eng_start));

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|eng_start) |-> array_busy);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_count != $past(cycle_count)) |-> (cycle_count == $past(cycle_count) + CNT_W'(1)));

    assert_count_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_count != $past(cycle_count)) |-> $past(|eng_done));

    assert_lm_idle_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|lm_req) |-> !array_busy);

    assert_lm_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lm_req));

    assert_err_with_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> host_ack);

endmodule

bind lockstep_array_ctrl array_ctrl_checker #(
    .NUM_ENG (NUM_ENG),
    .CNT_W   (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .eng_start   (eng_start),
    .eng_done    (eng_done),
    .lm_req      (lm_req),
    .array_busy  (array_busy),
    .host_ack    (host_ack),
    .host_err    (host_err),
    .cycle_count (cycle_count)
);

// File: tb/lockstep_array_ctrl_test.sv
`timescale 1ns/1ps
module lockstep_array_ctrl_test;

    localparam int NE = 4;
    localparam int DW = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_req = 1'b0;
    logic [2:0]        host_op = 3'd0;
    logic [1:0]        host_eng = 2'd0;
    logic [15:0]       host_addr = 16'd0;
    logic [DW-1:0]     host_wdata = '0;
    logic              host_ack, host_err, array_busy;
    logic [DW-1:0]     host_rdata;
    logic [NE-1:0]     eng_start, eng_done;
    logic              sm_req, sm_we, sm_ack_r;
    logic [15:0]       sm_addr;
    logic [DW-1:0]     sm_wdata, sm_rdata;
    logic [NE-1:0]     lm_req, lm_ack_r;
    logic              lm_we;
    logic [11:0]       lm_addr;
    logic [DW-1:0]     lm_wdata;
    logic [NE*DW-1:0]  lm_rdata;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int start_cnt = 0;
    int last_start = 0;
    int start_gap = 0;
    int lockstep_bad = 0;
    int lm_bad = 0;
    int eng_delay [NE];
    logic [7:0]    ecnt [NE];
    logic [DW-1:0] sm_mem [16];
    logic [DW-1:0] lm_mem [NE][16];
    logic [1:0]    sm_wait;

    always #2.5 clk = ~clk;

    lockstep_array_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_op(host_op), .host_eng(host_eng),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_err(host_err), .host_rdata(host_rdata),
        .array_busy(array_busy), .eng_start(eng_start), .eng_done(eng_done),
        .sm_req(sm_req), .sm_we(sm_we), .sm_addr(sm_addr), .sm_wdata(sm_wdata),
        .sm_rdata(sm_rdata), .sm_ack(sm_ack_r),
        .lm_req(lm_req), .lm_we(lm_we), .lm_addr(lm_addr), .lm_wdata(lm_wdata),
        .lm_rdata(lm_rdata), .lm_ack(lm_ack_r)
    );

    // Engine models: done pulse eng_delay clocks after the start pulse.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NE; i++) begin
            if (!rst_n)             ecnt[i] <= 8'd0;
            else if (eng_start[i])  ecnt[i] <= 8'(eng_delay[i]);
            else if (ecnt[i] != 0)  ecnt[i] <= ecnt[i] - 8'd1;
        end
    end
    always_comb begin
        for (int i = 0; i < NE; i++) eng_done[i] = (ecnt[i] == 8'd1);
    end

    // Shared memory model: acknowledge two clocks into a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sm_ack_r <= 1'b0;
            sm_wait  <= 2'd0;
            for (int j = 0; j < 16; j++) sm_mem[j] <= '0;
        end else begin
            sm_ack_r <= sm_req && !sm_ack_r && (sm_wait == 2'd1);
            sm_wait  <= (sm_req && !sm_ack_r) ? sm_wait + 2'd1 : 2'd0;
            if (sm_req && sm_ack_r && sm_we) sm_mem[sm_addr[3:0]] <= sm_wdata;
        end
    end
    assign sm_rdata = sm_mem[sm_addr[3:0]];

    // Private memory models: acknowledge one clock into a request.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NE; i++) begin
            if (!rst_n) begin
                lm_ack_r[i] <= 1'b0;
                for (int j = 0; j < 16; j++) lm_mem[i][j] <= 32'h1000_0000 + DW'(i * 256 + j);
            end else begin
                lm_ack_r[i] <= lm_req[i] && !lm_ack_r[i];
                if (lm_req[i] && lm_ack_r[i] && lm_we) lm_mem[i][lm_addr[3:0]] <= lm_wdata;
            end
        end
    end
    always_comb begin
        for (int i = 0; i < NE; i++) lm_rdata[i*DW +: DW] = lm_mem[i][lm_addr[3:0]];
    end

    // Port monitor.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (|eng_start) begin
                start_cnt = start_cnt + 1;
                start_gap = cyc - last_start;
                last_start = cyc;
                if (eng_start != {NE{1'b1}}) lockstep_bad = lockstep_bad + 1;
            end
            if ((|lm_req) && array_busy) lm_bad = lm_bad + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_xfer(input logic [2:0] op, input logic [1:0] eng, input logic [15:0] addr,
                             input logic [31:0] wd, output logic [31:0] rd, output logic err);
        int n;
        @(negedge clk);
        host_req = 1'b1; host_op = op; host_eng = eng; host_addr = addr; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        n = 0;
        while (!host_ack && n < 50) begin @(negedge clk); n++; end
        rd = host_rdata;
        err = host_ack ? host_err : 1'b1;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (array_busy && n < 500) begin @(negedge clk); n++; end
    endtask

    task automatic wait_starts(input int target);
        int n = 0;
        while (start_cnt < target && n < 500) begin @(negedge clk); n++; end
    endtask

    task automatic set_delays(input int a, input int b, input int c, input int d);
        eng_delay[0] = a; eng_delay[1] = b; eng_delay[2] = c; eng_delay[3] = d;
    endtask

    task automatic test_reset_r1();
        logic [31:0] rd; logic e;
        check("R1 busy", 32'(array_busy), 0);
        check("R1 start", 32'(eng_start), 0);
        check("R1 ack", 32'(host_ack), 0);
        host_xfer(3'd7, 2'd0, 16'd1, 0, rd, e);
        check("R1 count", rd, 0);
    endtask

    task automatic test_step_r2();
        logic [31:0] rd; logic e; int s0;
        set_delays(1, 1, 1, 1);
        s0 = start_cnt;
        host_xfer(3'd0, 2'd0, 16'd0, 0, rd, e);
        check("R2 step err", 32'(e), 0);
        wait_idle();
        repeat (4) @(negedge clk);
        check("R2 one start", 32'(start_cnt), 32'(s0 + 1));
        host_xfer(3'd7, 2'd0, 16'd1, 0, rd, e);
        check("R2 count", rd, 1);
        host_xfer(3'd2, 2'd0, 16'd0, 0, rd, e);
        check("R2 halt idle err", 32'(e), 0);
        repeat (3) @(negedge clk);
        check("R2 halt idle busy", 32'(array_busy), 0);
        check("R11 lockstep", 32'(lockstep_bad), 0);
    endtask

    task automatic test_join_r3();
        logic [31:0] rd; logic e; int n;
        set_delays(1, 3, 5, 7);
        host_xfer(3'd0, 2'd0, 16'd0, 0, rd, e);
        n = 0;
        while (array_busy && n < 100) begin n++; @(negedge clk); end
        check("R3 busy span", 32'(n), 8);
        host_xfer(3'd7, 2'd0, 16'd1, 0, rd, e);
        check("R3 count", rd, 2);
    endtask

    task automatic test_run_r4();
        logic [31:0] rd; logic e; int s0;
        set_delays(2, 2, 2, 2);
        s0 = start_cnt;
        host_xfer(3'd1, 2'd0, 16'd0, 0, rd, e);
        check("R4 run err", 32'(e), 0);
        wait_starts(s0 + 4);
        check("R4 gap", 32'(start_gap), 3);
        check("R4 busy", 32'(array_busy), 1);
    endtask

    task automatic test_busy_lm_r7();
        logic [31:0] rd; logic e;
        host_xfer(3'd6, 2'd1, 16'd3, 32'hDEAD_0103, rd, e);
        check("R7 write refused", 32'(e), 1);
        host_xfer(3'd5, 2'd1, 16'd3, 0, rd, e);
        check("R7 read refused", 32'(e), 1);
        check("R7 no lm_req", 32'(lm_bad), 0);
        check("R7 mem kept", lm_mem[1][3], 32'h1000_0103);
    endtask

    task automatic test_live_sm_r8();
        logic [31:0] rd; logic e;
        host_xfer(3'd4, 2'd0, 16'd9, 32'hCAFE_0009, rd, e);
        check("R8 write err", 32'(e), 0);
        check("R8 mem", sm_mem[9], 32'hCAFE_0009);
        host_xfer(3'd3, 2'd0, 16'd9, 0, rd, e);
        check("R8 read", rd, 32'hCAFE_0009);
        check("R8 read err", 32'(e), 0);
    endtask

    task automatic test_refuse_r10();
        logic [31:0] rd; logic e;
        host_xfer(3'd7, 2'd0, 16'd0, 0, rd, e);
        check("R9 busy bit", rd, 1);
        host_xfer(3'd0, 2'd0, 16'd0, 0, rd, e);
        check("R10 step refused", 32'(e), 1);
        host_xfer(3'd1, 2'd0, 16'd0, 0, rd, e);
        check("R10 run refused", 32'(e), 1);
    endtask

    task automatic test_halt_mid_r5();
        logic [31:0] rd; logic e; int s0; int sc;
        s0 = start_cnt;
        wait_starts(s0 + 1);
        host_xfer(3'd2, 2'd0, 16'd0, 0, rd, e);
        sc = start_cnt;
        wait_idle();
        repeat (6) @(negedge clk);
        check("R5 no restart", 32'(start_cnt), 32'(sc));
        host_xfer(3'd7, 2'd0, 16'd1, 0, rd, e);
        check("R5 cycle completed", rd, 32'(start_cnt));
        check("R10 no extra cycle", rd, 32'(start_cnt));
    endtask

    task automatic test_halt_edge_r5();
        logic [31:0] rd; logic e; int n; int sc;
        set_delays(3, 3, 3, 3);
        host_xfer(3'd1, 2'd0, 16'd0, 0, rd, e);
        wait_starts(start_cnt + 2);
        n = 0;
        while (eng_done != {NE{1'b1}} && n < 50) begin @(negedge clk); n++; end
        host_req = 1'b1; host_op = 3'd2; host_eng = 2'd0; host_addr = 16'd0;
        sc = start_cnt;
        @(negedge clk);
        host_req = 1'b0;
        check("R5 coincident ack", 32'(host_ack), 1);
        check("R5 coincident idle", 32'(array_busy), 0);
        repeat (6) @(negedge clk);
        check("R5 coincident no restart", 32'(start_cnt), 32'(sc));
        host_xfer(3'd7, 2'd0, 16'd1, 0, rd, e);
        check("R5 coincident count", rd, 32'(start_cnt));
    endtask

    task automatic test_idle_lm_r6();
        logic [31:0] rd; logic e;
        host_xfer(3'd6, 2'd2, 16'd5, 32'hA5A5_0205, rd, e);
        check("R6 write err", 32'(e), 0);
        check("R6 mem written", lm_mem[2][5], 32'hA5A5_0205);
        check("R6 neighbour kept", lm_mem[1][5], 32'h1000_0105);
        host_xfer(3'd5, 2'd2, 16'd5, 0, rd, e);
        check("R6 read", rd, 32'hA5A5_0205);
        host_xfer(3'd5, 2'd1, 16'd3, 0, rd, e);
        check("R7 word unchanged", rd, 32'h1000_0103);
        host_xfer(3'd7, 2'd0, 16'd0, 0, rd, e);
        check("R9 idle busy bit", rd, 0);
    endtask

    initial begin
        set_delays(1, 1, 1, 1);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset_r1();
        test_step_r2();
        test_join_r3();
        test_run_r4();
        test_busy_lm_r7();
        test_live_sm_r8();
        test_refuse_r10();
        test_halt_mid_r5();
        test_halt_edge_r5();
        test_idle_lm_r6();
        check("R11 lockstep all", 32'(lockstep_bad), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks = checks + 1;
        fails = fails + 1;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule